// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two strobes that an 8051-style core drives toward external memory. The first is the address-latch pulse `ale_o`, active high. The second is the program-read strobe `psen_n_o`, active low. The core supplies a machine-cycle phase count running from 0 to 11, clocked by the oscillator. It also supplies four per-cycle flags:

- executing from external code;
- the current cycle is an external data move;
- the current cycle is a code-table read;
- the software ALE-disable bit (bit 0 of the auxiliary register at SFR address 8EH, which is held outside this block).

Each machine cycle has two halves of `HALF_LEN` oscillator periods. Each half carries one fixed address-latch window and one fixed program-read window. The block decides, cycle by cycle, which of these pulses are issued and which are suppressed. The flags are captured when the phase reads 0, so the decision is constant for the whole machine cycle. Both outputs come from registers and follow the phase input by one clock.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst_i` is high, `ale_o` is 0 and `psen_n_o` is 1 from the next clock on.
- R2: With default parameters, no flags set and ALE enabled, `ale_o` is 1 exactly one clock after phases 0, 1, 6 and 7, and 0 after every other phase. This gives one 2-period pulse every 6 oscillator periods.
- R3: With external execution and no data move, `psen_n_o` is 0 one clock after phases 2, 3, 4, 8, 9 and 10, and 1 otherwise. Each low pulse therefore starts after the ALE pulse has ended, lasts 3 periods, and occurs twice per machine cycle.
- R4: When external execution is not flagged, `psen_n_o` stays 1 for every phase.
- R5: In a data-move cycle, the ALE pulse of the second half (phases 6 and 7) is omitted. The first-half pulse is kept.
- R6: In a data-move cycle under external execution, both program-read pulses of that machine cycle are omitted.
- R7: With the disable bit set, no external execution, and neither a data move nor a table read, `ale_o` is held at 1 for every phase.
- R8: With the disable bit set, a data-move or table-read cycle still pulses `ale_o` as in R2. R5 still applies to data-move cycles.
- R9: The disable bit has no effect when external execution is flagged: `ale_o` follows R2 and R5.
- R10: Flags are sampled only when the phase input is 0. A flag change in phases 1 to 11 takes effect at the next phase 0.
- R11: Each output reflects the phase value presented one clock earlier.
- R12: A phase value of 12 or more produces no pulse: `psen_n_o` is 1, and `ale_o` is 0, or 1 under the R7 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| phase_i | input | PHASE_W (4) | Oscillator period index within the machine cycle |
| ext_exec_i | input | 1 | Core is fetching code from external memory |
| xdata_i | input | 1 | Current machine cycle is an external data move |
| ctab_i | input | 1 | Current machine cycle is a code-table read |
| ale_dis_i | input | 1 | Software ALE-disable bit |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Program-read strobe, active low |

## Verification
The checker holds the following on every cycle:

- the reset idle levels;
- that a program-read pulse never overlaps an address-latch pulse;
- that program reads occur only in external-execution cycles without a data move;
- the forced-high ALE level under software disable;
- the second-half ALE skip in data-move cycles;
- that the captured flags do not move outside phase 0;
- the silence on out-of-range phases.

The exact pulse placement and widths for every flag combination, and the effect of mid-cycle flag changes, can only be shown by the bench's phase sweeps. The bench compares each output against a value it computes arithmetically from the phase and the flags it latched itself.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

  // Flags describing one machine cycle, captured at phase 0.
  typedef struct packed {
    logic ext;   // running from external code
    logic xdat;  // external data move
    logic ctab;  // code-table read
    logic dis;   // software ALE-disable
  } cyc_ctx_t;

  localparam cyc_ctx_t CTX_IDLE = '{ext: 1'b0, xdat: 1'b0, ctab: 1'b0, dis: 1'b0};

endpackage

// File: rtl/strobe_phase_dec.sv
module strobe_phase_dec #(
  parameter int HALF_LEN   = 6,
  parameter int ALE_START  = 0,
  parameter int ALE_W      = 2,
  parameter int PSEN_START = 2,
  parameter int PSEN_W     = 3,
  parameter int PHASE_W    = 4
) (
  input  logic [PHASE_W-1:0] phase,
  output logic               is_zero,
  output logic               second_half,
  output logic               ale_win,
  output logic               psen_win
);

  localparam int CYC_LEN = 2 * HALF_LEN;

  logic [1:0] ale_hit;
  logic [1:0] psen_hit;
  int unsigned ph;

  assign ph = 32'(phase);

  // One window pair per half of the machine cycle.
  for (genvar g = 0; g < 2; g++) begin : g_half
    localparam int BASE = g * HALF_LEN;
    assign ale_hit[g]  = (ph >= BASE + ALE_START) &&
                         (ph <  BASE + ALE_START + ALE_W);
    assign psen_hit[g] = (ph >= BASE + PSEN_START) &&
                         (ph <  BASE + PSEN_START + PSEN_W);
  end

  assign is_zero     = (ph == 0);
  assign second_half = (ph >= HALF_LEN) && (ph < CYC_LEN);
  assign ale_win     = |ale_hit;
  assign psen_win    = |psen_hit;

endmodule

// File: rtl/strobe_ctx_latch.sv
module strobe_ctx_latch
  import strobe_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     capture,
  input  cyc_ctx_t ctx_in,
  output cyc_ctx_t ctx_eff,
  output cyc_ctx_t ctx_q
);

  // At phase 0 the fresh flags apply at once; later phases use the held copy.
  assign ctx_eff = capture ? ctx_in : ctx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q <= CTX_IDLE;
    end else if (capture) begin
      ctx_q <= ctx_in;
    end
  end

endmodule

// File: rtl/strobe_out_reg.sv
module strobe_out_reg
  import strobe_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  cyc_ctx_t ctx,
  input  logic     second_half,
  input  logic     ale_win,
  input  logic     psen_win,
  output logic     ale_q,
  output logic     psen_n_q
);

  logic hold_high;
  logic ale_skip;
  logic ale_d;
  logic psen_n_d;

  // Disable only bites for internal execution outside data/table cycles.
  assign hold_high = ctx.dis & ~ctx.ext & ~ctx.xdat & ~ctx.ctab;
  assign ale_skip  = ctx.xdat & second_half;
  assign ale_d     = hold_high | (ale_win & ~ale_skip);
  assign psen_n_d  = ~(psen_win & ctx.ext & ~ctx.xdat);

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q    <= 1'b0;
      psen_n_q <= 1'b1;
    end else begin
      ale_q    <= ale_d;
      psen_n_q <= psen_n_d;
    end
  end

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import strobe_pkg::*;
#(
  parameter int HALF_LEN   = 6,
  parameter int ALE_START  = 0,
  parameter int ALE_W      = 2,
  parameter int PSEN_START = 2,
  parameter int PSEN_W     = 3,
  localparam int PHASE_W   = $clog2(2 * HALF_LEN)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               ext_exec_i,
  input  logic               xdata_i,
  input  logic               ctab_i,
  input  logic               ale_dis_i,
  output logic               ale_o,
  output logic               psen_n_o
);

  cyc_ctx_t ctx_in;
  cyc_ctx_t eff_ctx;
  cyc_ctx_t ctx_q;
  logic     ph_zero;
  logic     ph_second;
  logic     win_ale;
  logic     win_psen;

  assign ctx_in = '{ext: ext_exec_i, xdat: xdata_i, ctab: ctab_i, dis: ale_dis_i};

  strobe_phase_dec #(
    .HALF_LEN  (HALF_LEN),
    .ALE_START (ALE_START),
    .ALE_W     (ALE_W),
    .PSEN_START(PSEN_START),
    .PSEN_W    (PSEN_W),
    .PHASE_W   (PHASE_W)
  ) u_dec (
    .phase      (phase_i),
    .is_zero    (ph_zero),
    .second_half(ph_second),
    .ale_win    (win_ale),
    .psen_win   (win_psen)
  );

  strobe_ctx_latch u_ctx (
    .clk    (clk_i),
    .rst    (rst_i),
    .capture(ph_zero),
    .ctx_in (ctx_in),
    .ctx_eff(eff_ctx),
    .ctx_q  (ctx_q)
  );

  strobe_out_reg u_out (
    .clk        (clk_i),
    .rst        (rst_i),
    .ctx        (eff_ctx),
    .second_half(ph_second),
    .ale_win    (win_ale),
    .psen_win   (win_psen),
    .ale_q      (ale_o),
    .psen_n_q   (psen_n_o)
  );

endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk #(
  parameter int HALF_LEN = 6,
  parameter int PHASE_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [PHASE_W-1:0] phase,
  input logic               ale,
  input logic               psen_n,
  input logic               eff_ext,
  input logic               eff_xdat,
  input logic               eff_ctab,
  input logic               eff_dis,
  input logic [3:0]         held_ctx
);

  localparam int CYC_LEN = 2 * HALF_LEN;

  logic in_second;
  assign in_second = (32'(phase) >= HALF_LEN) && (32'(phase) < CYC_LEN);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!ale && psen_n));

  assert_psen_clear_of_ale_R3: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> !ale);

  // R4 and R6: a program read needs external execution and no data move.
  assert_psen_needs_ext_R4: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> $past(eff_ext && !eff_xdat));

  assert_xdata_skip_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(eff_xdat && in_second)) |-> !ale);

  assert_disable_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(eff_dis && !eff_ext && !eff_xdat && !eff_ctab)) |-> ale);

  assert_ctx_steady_R10: assert property (@(posedge clk) disable iff (rst)
    (phase != '0) |=> $stable(held_ctx));

  assert_range_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (32'(phase) >= CYC_LEN) |=> psen_n);

endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(
  .HALF_LEN(HALF_LEN),
  .PHASE_W (PHASE_W)
) u_chk (
  .clk     (clk_i),
  .rst     (rst_i),
  .phase   (phase_i),
  .ale     (ale_o),
  .psen_n  (psen_n_o),
  .eff_ext (eff_ctx.ext),
  .eff_xdat(eff_ctx.xdat),
  .eff_ctab(eff_ctx.ctab),
  .eff_dis (eff_ctx.dis),
  .held_ctx(ctx_q)
);

// File: tb/bus_strobe_gen_bench.sv
module bus_strobe_gen_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] phase;
  logic       ext, xd, ct, dis;
  logic       ale;
  logic       psen_n;

  int n_run  = 0;
  int n_fail = 0;

  // Flags the bench itself latched at the last phase 0.
  logic m_ext, m_xd, m_ct, m_dis;

  always #10 clk = ~clk;

  bus_strobe_gen u_bus_strobe_gen (
    .clk_i     (clk),
    .rst_i     (rst),
    .phase_i   (phase),
    .ext_exec_i(ext),
    .xdata_i   (xd),
    .ctab_i    (ct),
    .ale_dis_i (dis),
    .ale_o     (ale),
    .psen_n_o  (psen_n)
  );

  function automatic logic exp_ale(int p);
    logic hold;
    hold = m_dis && !m_ext && !m_xd && !m_ct;
    if (hold) return 1'b1;
    if (p >= 12) return 1'b0;
    if ((p % 6) >= 2) return 1'b0;
    if (m_xd && (p / 6) == 1) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic exp_psen_n(int p);
    if (p >= 12 || !m_ext || m_xd) return 1'b1;
    return !((p % 6) >= 2 && (p % 6) <= 4);
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s phase=%0d flags(e,x,c,d)=%b%b%b%b actual=%b expected=%b",
               req, what, phase, m_ext, m_xd, m_ct, m_dis, act, exp);
    end
  endtask

  // Drive one phase at a negedge; check both outputs after the next posedge.
  task automatic step(int p, logic e, logic x, logic c, logic d, string req);
    phase = 4'(p);
    ext = e; xd = x; ct = c; dis = d;
    if (p == 0) begin
      m_ext = e; m_xd = x; m_ct = c; m_dis = d;
    end
    @(posedge clk);
    #5;
    check(req, ale, exp_ale(p), "ale");
    check(req, psen_n, exp_psen_n(p), "psen_n");
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    rst = 1'b1;
    phase = 4'd0;
    ext = 1'b1; xd = 1'b0; ct = 1'b0; dis = 1'b1;
    m_ext = 1'b0; m_xd = 1'b0; m_ct = 1'b0; m_dis = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    // R1: idle levels during reset
    check("R1", ale, 1'b0, "ale");
    check("R1", psen_n, 1'b1, "psen_n");
    @(negedge clk);
    rst = 1'b0;

    // R2..R9, R11: sweep all flag combinations over two machine cycles each.
    for (int f = 0; f < 16; f++) begin
      for (int rep = 0; rep < 2; rep++) begin
        for (int p = 0; p < 12; p++) begin
          step(p, f[3], f[2], f[1], f[0], "R2/R3/R4/R5/R6/R7/R8/R9/R11");
        end
      end
    end

    // R10: flags changing mid-cycle must wait for the next phase 0.
    for (int f = 0; f < 16; f++) begin
      step(0, f[3], f[2], f[1], f[0], "R10");
      for (int p = 1; p < 12; p++) begin
        step(p, ~f[3], ~f[2], ~f[1], ~f[0], "R10");
      end
    end

    // R12: phase values beyond the machine cycle produce no pulse.
    for (int f = 0; f < 16; f++) begin
      step(0, f[3], f[2], f[1], f[0], "R12");
      for (int p = 12; p < 16; p++) begin
        step(p, f[3], f[2], f[1], f[0], "R12");
      end
    end

    // R1: reset taken mid-cycle returns the outputs to idle.
    step(0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
    phase = 4'd2;
    rst = 1'b1;
    @(posedge clk);
    #5;
    check("R1", ale, 1'b0, "ale");
    check("R1", psen_n, 1'b1, "psen_n");
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule